// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block models the device side of a three-wire serial EEPROM as synthesizable logic that runs on a fast system clock. The host drives a chip select, a slow serial clock and a serial data line. The block samples all three through synchronizers and acts on rising edges of the serial clock. It returns read data and ready/busy status on a serial output with a separate output enable, which stands in for a tri-state pin.

The storage is a 16 Kbit array of 16-bit words kept in registers. A strap input chooses how the host sees the array. When the strap is high, the host sees 16-bit words with a 10-bit address. When it is low, the host sees bytes with an 11-bit address.

Writes are guarded by a program-enable latch. Each write, erase, write-all or erase-all runs a self-timed cycle whose length in system clocks is a parameter. The memory changes when that cycle ends.

Top module: `serial_eeprom_dev`

## Requirements
- R1: After reset the serial output enable is low and programming is disabled.
- R2: A command starts with a 1 sampled on a serial-clock rising edge while chip select is high, followed by a 2-bit opcode (10 read, 01 write, 11 erase, 00 special), the address MSB first, and for writes the data word MSB first.
- R3: While programming is disabled, write, erase, write-all and erase-all start no program cycle and leave the memory unchanged. Read works whether programming is enabled or not.
- R4: Under opcode 00 the two most significant address bits select the command: 11 enables programming, 00 disables it, 10 erases all words, 01 writes the following data word to every location. The other address bits are ignored.
- R5: A read drives the output enable and presents a 0 dummy bit once the last address bit is taken. Each later serial-clock rising edge then presents the next data bit, MSB first.
- R6: Clocking on past the end of a read word presents the next address's word with no dummy bit. The address wraps from the last location to 0.
- R7: With the strap high, the address is 10 bits and words are 16 bits. With the strap low, the address is 11 bits and words are bytes, and an even byte address selects the low half of a 16-bit word.
- R8: Erase sets every bit of the addressed word to 1. A write stores its data without a prior erase.
- R9: A program cycle starts after the last data bit of a write or write-all, or once the address of an erase or erase-all is taken. It lasts PROG_CYCLES system clocks, and the memory is updated when it ends.
- R10: If chip select rises while a program cycle is running, the output is driven with 0 while busy and 1 once ready, until chip select falls. If chip select rises after the cycle has ended, nothing is driven.
- R11: The output enable is low whenever chip select is low.
- R12: A command cut short by chip select falling is dropped, and programming never starts from a partial command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data in |
| orgWide | input | 1 | Organization strap: 1 selects 16-bit words, 0 selects bytes |
| serOut | output | 1 | Serial data out value |
| serOutEn | output | 1 | Serial data out drive enable (0 means high impedance) |

## Verification
The hardest case to reach is the status window. Chip select has to be dropped and raised again between the final data bit and the end of the self-timed cycle. It also has to be raised after the cycle ends, to show that nothing is driven then. The bench closes each program command and reopens chip select within a few serial-clock periods, so the first status sample lands well inside the cycle. It then waits past the cycle length before taking the ready sample, and in a separate test waits with chip select low before raising it. Aborts are made by dropping chip select partway through a data word, and after each one the status window and a read-back show that no cycle started.

// File: rtl/serial_eeprom_pkg.sv
`timescale 1ns/1ps
package serial_eeprom_pkg;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } opCodeT;

  typedef enum logic [1:0] {
    SUB_DISABLE  = 2'b00,
    SUB_WRITEALL = 2'b01,
    SUB_ERASEALL = 2'b10,
    SUB_ENABLE   = 2'b11
  } subCodeT;

  // strobes from control to datapath
  typedef struct packed {
    logic addrShift;
    logic dataShift;
    logic readLoad;
    logic readShift;
    logic readNext;
    logic progStart;
    logic progBulk;
    logic progErase;
  } strobeT;

endpackage

// File: rtl/serial_eeprom_sync.sv
`timescale 1ns/1ps
module serial_eeprom_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : gBit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/serial_eeprom_datapath.sv
`timescale 1ns/1ps
module serial_eeprom_datapath
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_ADDR_W = 10,
  parameter int WIDE_W      = 16,
  parameter int PROG_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       orgWide,
  input  logic       diBit,
  input  strobeT     strb,
  output logic       outBit,
  output logic       busy,
  output logic [1:0] addrTop
);

  localparam int WORDS       = 1 << WORD_ADDR_W;
  localparam int BYTE_ADDR_W = WORD_ADDR_W + 1;
  localparam int NARROW_W    = WIDE_W / 2;
  localparam int PCNT_W      = $clog2(PROG_CYCLES + 1);

  logic [WIDE_W-1:0]      mem [WORDS];
  logic [BYTE_ADDR_W-1:0] addrQ;
  logic [BYTE_ADDR_W-1:0] addrInc;
  logic [WIDE_W-1:0]      shQ;
  logic                   outQ;
  logic [PCNT_W-1:0]      progCnt;
  logic [WORD_ADDR_W-1:0] pendIdx;
  logic [WIDE_W-1:0]      pendData;
  logic [WIDE_W-1:0]      pendMask;
  logic                   pendBulk;
  logic [WORD_ADDR_W-1:0] wordIdx;
  logic                   byteSel;
  logic [WIDE_W-1:0]      curAligned;
  logic [WIDE_W-1:0]      nextAligned;
  logic                   commit;

  // fetch a word for shifting out, left aligned
  function automatic logic [WIDE_W-1:0] fetch(input logic [BYTE_ADDR_W-1:0] a, input logic wide);
    logic [WIDE_W-1:0] w;
    if (wide) begin
      w = mem[a[WORD_ADDR_W-1:0]];
      return w;
    end
    w = mem[a[BYTE_ADDR_W-1:1]];
    if (a[0]) return {w[WIDE_W-1 -: NARROW_W], NARROW_W'(0)};
    return {w[NARROW_W-1:0], NARROW_W'(0)};
  endfunction

  always_comb begin
    wordIdx     = orgWide ? addrQ[WORD_ADDR_W-1:0] : addrQ[BYTE_ADDR_W-1:1];
    byteSel     = addrQ[0];
    addrTop     = orgWide ? addrQ[WORD_ADDR_W-1 -: 2] : addrQ[BYTE_ADDR_W-1 -: 2];
    addrInc     = addrQ + BYTE_ADDR_W'(1);
    curAligned  = fetch(addrQ, orgWide);
    nextAligned = fetch(addrInc, orgWide);
    commit      = (progCnt == PCNT_W'(1));
  end

  // address, shift and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      shQ   <= '0;
      outQ  <= 1'b0;
    end else begin
      if (strb.addrShift) addrQ <= {addrQ[BYTE_ADDR_W-2:0], diBit};
      if (strb.dataShift) shQ   <= {shQ[WIDE_W-2:0], diBit};
      if (strb.readLoad) begin
        shQ  <= curAligned;
        outQ <= 1'b0;
      end
      if (strb.readShift) begin
        outQ <= shQ[WIDE_W-1];
        shQ  <= {shQ[WIDE_W-2:0], 1'b0};
      end
      if (strb.readNext) begin
        outQ  <= shQ[WIDE_W-1];
        shQ   <= nextAligned;
        addrQ <= addrInc;
      end
    end
  end

  // self-timed program cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt  <= '0;
      pendIdx  <= '0;
      pendData <= '0;
      pendMask <= '0;
      pendBulk <= 1'b0;
    end else if (strb.progStart) begin
      progCnt  <= PCNT_W'(PROG_CYCLES);
      pendIdx  <= wordIdx;
      pendBulk <= strb.progBulk;
      if (strb.progErase)  pendData <= '1;
      else if (orgWide)    pendData <= shQ;
      else                 pendData <= {shQ[NARROW_W-1:0], shQ[NARROW_W-1:0]};
      if (strb.progBulk || orgWide) pendMask <= '1;
      else if (byteSel)             pendMask <= {{NARROW_W{1'b1}}, {NARROW_W{1'b0}}};
      else                          pendMask <= {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};
    end else if (progCnt != '0) begin
      progCnt <= progCnt - PCNT_W'(1);
    end
  end

  // storage array, not reset
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < WORDS; i++) begin
        if (pendBulk || pendIdx == WORD_ADDR_W'(i))
          mem[i] <= (mem[i] & ~pendMask) | (pendData & pendMask);
      end
    end
  end

  assign busy   = (progCnt != '0);
  assign outBit = outQ;

endmodule

// File: rtl/serial_eeprom_ctrl.sv
`timescale 1ns/1ps
module serial_eeprom_ctrl
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_ADDR_W = 10,
  parameter int WIDE_W      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       skS,
  input  logic       diS,
  input  logic       orgWide,
  input  logic       busy,
  input  logic [1:0] addrTop,
  input  logic       outBit,
  output strobeT     strb,
  output logic       serOut,
  output logic       serOutEn,
  output logic       progEn
);

  localparam int CNT_W = $clog2(WIDE_W + WORD_ADDR_W + 2);

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_EXEC, ST_DATA, ST_PROG, ST_READ, ST_STATUS, ST_DONE
  } stateT;

  stateT             state, stateD;
  logic [CNT_W-1:0]  bitCnt, bitCntD;
  logic [1:0]        opQ, opD;
  logic              enD;
  logic              skPrev, csPrev;
  logic              skRise, csRise;
  logic [CNT_W-1:0]  addrLast, dataLast;

  assign skRise   = skS & ~skPrev;
  assign csRise   = csS & ~csPrev;
  assign addrLast = orgWide ? CNT_W'(WORD_ADDR_W - 1) : CNT_W'(WORD_ADDR_W);
  assign dataLast = orgWide ? CNT_W'(WIDE_W - 1) : CNT_W'(WIDE_W / 2 - 1);

  always_comb begin
    strb    = '0;
    stateD  = state;
    bitCntD = bitCnt;
    opD     = opQ;
    enD     = progEn;
    if (!csS) begin
      stateD = ST_IDLE;
    end else if (csRise && busy) begin
      stateD = ST_STATUS;
    end else begin
      unique case (state)
        ST_IDLE: if (skRise && diS && !busy) begin
          stateD  = ST_OPC;
          bitCntD = '0;
        end
        ST_OPC: if (skRise) begin
          opD = {opQ[0], diS};
          if (bitCnt == CNT_W'(1)) begin
            stateD  = ST_ADDR;
            bitCntD = '0;
          end else bitCntD = bitCnt + CNT_W'(1);
        end
        ST_ADDR: if (skRise) begin
          strb.addrShift = 1'b1;
          if (bitCnt == addrLast) begin
            stateD  = ST_EXEC;
            bitCntD = '0;
          end else bitCntD = bitCnt + CNT_W'(1);
        end
        ST_EXEC: begin
          stateD = ST_DONE;
          unique case (opCodeT'(opQ))
            OP_READ: begin
              strb.readLoad = 1'b1;
              stateD        = ST_READ;
            end
            OP_WRITE: stateD = ST_DATA;
            OP_ERASE: if (progEn) begin
              strb.progStart = 1'b1;
              strb.progErase = 1'b1;
            end
            OP_SPECIAL: begin
              unique case (subCodeT'(addrTop))
                SUB_ENABLE:   enD = 1'b1;
                SUB_DISABLE:  enD = 1'b0;
                SUB_ERASEALL: if (progEn) begin
                  strb.progStart = 1'b1;
                  strb.progErase = 1'b1;
                  strb.progBulk  = 1'b1;
                end
                SUB_WRITEALL: stateD = ST_DATA;
              endcase
            end
          endcase
        end
        ST_DATA: if (skRise) begin
          strb.dataShift = 1'b1;
          if (bitCnt == dataLast) stateD = ST_PROG;
          else bitCntD = bitCnt + CNT_W'(1);
        end
        ST_PROG: begin
          if (progEn) begin
            strb.progStart = 1'b1;
            strb.progBulk  = (opCodeT'(opQ) == OP_SPECIAL);
          end
          stateD = ST_DONE;
        end
        ST_READ: if (skRise) begin
          if (bitCnt == dataLast) begin
            strb.readNext = 1'b1;
            bitCntD       = '0;
          end else begin
            strb.readShift = 1'b1;
            bitCntD        = bitCnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      opQ    <= '0;
      progEn <= 1'b0;
      skPrev <= 1'b0;
      csPrev <= 1'b0;
    end else begin
      state  <= stateD;
      bitCnt <= bitCntD;
      opQ    <= opD;
      progEn <= enD;
      skPrev <= skS;
      csPrev <= csS;
    end
  end

  assign serOutEn = csS && (state == ST_READ || state == ST_STATUS);
  assign serOut   = (state == ST_STATUS) ? !busy : outBit;

endmodule

// File: rtl/serial_eeprom_dev.sv
`timescale 1ns/1ps
module serial_eeprom_dev
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_ADDR_W = 10,
  parameter int WIDE_W      = 16,
  parameter int PROG_CYCLES = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic orgWide,
  output logic serOut,
  output logic serOutEn
);

  logic       csSync, skSync, diSync;
  logic       progBusy, progEnable, outBit;
  logic [1:0] addrTop;
  strobeT     strb;

  serial_eeprom_sync #(.WIDTH(3), .STAGES(2)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({csIn, skIn, diIn}),
    .dout ({csSync, skSync, diSync})
  );

  serial_eeprom_ctrl #(.WORD_ADDR_W(WORD_ADDR_W), .WIDE_W(WIDE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csS      (csSync),
    .skS      (skSync),
    .diS      (diSync),
    .orgWide  (orgWide),
    .busy     (progBusy),
    .addrTop  (addrTop),
    .outBit   (outBit),
    .strb     (strb),
    .serOut   (serOut),
    .serOutEn (serOutEn),
    .progEn   (progEnable)
  );

  serial_eeprom_datapath #(
    .WORD_ADDR_W (WORD_ADDR_W),
    .WIDE_W      (WIDE_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .orgWide (orgWide),
    .diBit   (diSync),
    .strb    (strb),
    .outBit  (outBit),
    .busy    (progBusy),
    .addrTop (addrTop)
  );

endmodule

// File: rtl/serial_eeprom_checker.sv
`timescale 1ns/1ps
module serial_eeprom_checker (
  input logic clk,
  input logic rstN,
  input logic csSync,
  input logic serOutEn,
  input logic busy,
  input logic progEn,
  input logic progStart,
  input logic readLoad,
  input logic outBit
);

  a_r11_off_when_cs_low: assert property (@(posedge clk) disable iff (!rstN)
    !csSync |-> !serOutEn);

  a_r3_cycle_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(progEn));

  a_r12_start_with_cs: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> csSync);

  a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rstN)
    readLoad |=> !outBit);

  a_r9_no_restart_busy: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> !busy);

endmodule

bind serial_eeprom_dev serial_eeprom_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csSync    (csSync),
  .serOutEn  (serOutEn),
  .busy      (progBusy),
  .progEn    (progEnable),
  .progStart (strb.progStart),
  .readLoad  (strb.readLoad),
  .outBit    (outBit)
);

// File: tb/test_serial_eeprom_dev.sv
`timescale 1ns/1ps
module test_serial_eeprom_dev;

  localparam int PROG = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, orgW = 1'b1;
  logic serOut, serOutEn;
  int   checks = 0, failures = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_eeprom_dev #(.WORD_ADDR_W(10), .WIDE_W(16), .PROG_CYCLES(PROG)) i_serial_eeprom_dev (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di),
    .orgWide(orgW), .serOut(serOut), .serOutEn(serOutEn)
  );

  // {wide, addr[10:0], data[15:0]}
  localparam logic [27:0] VECS [0:5] = '{
    {1'b1, 11'd0,    16'h1234},
    {1'b1, 11'd17,   16'h0001},
    {1'b1, 11'd512,  16'h8000},
    {1'b0, 11'd100,  16'h00C3},
    {1'b0, 11'd101,  16'h007E},
    {1'b1, 11'd1000, 16'hFFFE}
  };

  task automatic clkWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    di = b; clkWait(4);
    sk = 1'b1; clkWait(8);
    sk = 1'b0; clkWait(4);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic csUp();   cs = 1'b1; clkWait(6); endtask
  task automatic csDown(); cs = 1'b0; di = 1'b0; clkWait(6); endtask

  function automatic int aw(); return orgW ? 10 : 11; endfunction
  function automatic int dw(); return orgW ? 16 : 8;  endfunction

  task automatic issue(input logic [1:0] op, input logic [10:0] addr);
    csUp(); pulse(1'b1); sendBits({30'd0, op}, 2); sendBits({21'd0, addr}, aw());
  endtask

  task automatic special(input logic [1:0] sub);
    issue(2'b00, 11'(sub) << (aw() - 2));
  endtask

  task automatic cmdWrite(input logic [10:0] a, input logic [15:0] d);
    issue(2'b01, a); sendBits({16'd0, d}, dw()); csDown();
  endtask

  task automatic readStart(input logic [10:0] a);
    issue(2'b10, a);
  endtask

  task automatic readWord(output logic [15:0] w);
    w = '0;
    for (int i = 0; i < dw(); i++) begin
      pulse(1'b0);
      w = {w[14:0], serOut};
    end
  endtask

  task automatic readCheck(input string req, input logic [10:0] a, input logic [15:0] exp);
    logic [15:0] w;
    readStart(a); readWord(w); csDown();
    check(req, {16'd0, w}, {16'd0, exp});
  endtask

  task automatic waitProg(); clkWait(PROG + 40); endtask

  task automatic noStatus(input string req);
    csUp(); check(req, {31'd0, serOutEn}, 32'd0); csDown();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    clkWait(5); rstN = 1'b1; clkWait(5);

    // R1: reset state
    check("R1 oe after reset", {31'd0, serOutEn}, 32'd0);
    // R1 R3: disabled at reset, write starts no cycle
    cmdWrite(11'd5, 16'h1234);
    noStatus("R3 no cycle while disabled");

    // R4 enable, R9 R10 status window, R11
    special(2'b11); csDown();
    cmdWrite(11'd5, 16'hCAFE);
    csUp();
    check("R10 status driven", {31'd0, serOutEn}, 32'd1);
    check("R10 busy value", {31'd0, serOut}, 32'd0);
    waitProg();
    check("R10 ready value", {31'd0, serOut}, 32'd1);
    csDown();
    check("R11 oe off cs low", {31'd0, serOutEn}, 32'd0);

    // R5 dummy bit then word, R2 framing
    readStart(11'd5);
    check("R5 dummy oe", {31'd0, serOutEn}, 32'd1);
    check("R5 dummy zero", {31'd0, serOut}, 32'd0);
    readWord(w); csDown();
    check("R5 R2 read word", {16'd0, w}, 32'h0000CAFE);

    // table walk: write then read back (R7 R9)
    for (int i = 0; i < 6; i++) begin
      orgW = VECS[i][27];
      cmdWrite(VECS[i][26:16], VECS[i][15:0]);
      waitProg();
      readCheck("R9 table readback", VECS[i][26:16], orgW ? VECS[i][15:0] : {8'd0, VECS[i][7:0]});
    end
    orgW = 1'b1;
    readCheck("R7 even byte low half", 11'd50, 16'h7EC3);

    // R7 cross organization
    cmdWrite(11'd3, 16'hA55A); waitProg();
    orgW = 1'b0;
    readCheck("R7 byte 6", 11'd6, 16'h005A);
    readCheck("R7 byte 7", 11'd7, 16'h00A5);
    cmdWrite(11'd7, 16'h003C); waitProg();
    orgW = 1'b1;
    readCheck("R7 byte write merge", 11'd3, 16'h3C5A);

    // R8 erase then write without erase
    issue(2'b11, 11'd3); csDown();
    csUp(); check("R9 erase starts cycle", {31'd0, serOutEn}, 32'd1); csDown();
    waitProg();
    readCheck("R8 erase ones", 11'd3, 16'hFFFF);
    cmdWrite(11'd3, 16'h0F0F); waitProg();
    readCheck("R8 write no erase", 11'd3, 16'h0F0F);

    // R6 sequential read and wrap
    cmdWrite(11'd1023, 16'h1111); waitProg();
    cmdWrite(11'd0, 16'h2222); waitProg();
    readStart(11'd1023);
    readWord(w); check("R6 first word", {16'd0, w}, 32'h1111);
    readWord(w); check("R6 wrap no dummy", {16'd0, w}, 32'h2222);
    // R11 mid-read drop
    pulse(1'b0); pulse(1'b0);
    cs = 1'b0; clkWait(6);
    check("R11 oe off mid read", {31'd0, serOutEn}, 32'd0);
    orgW = 1'b0;
    readStart(11'd2047);
    readWord(w); check("R6 byte last", {16'd0, w}, 32'h0011);
    readWord(w); check("R6 byte wrap", {16'd0, w}, 32'h0022);
    csDown();
    orgW = 1'b1;

    // R4 erase all / write all
    special(2'b10); csDown();
    csUp(); check("R9 erase-all busy", {31'd0, serOut}, 32'd0); csDown();
    waitProg();
    readCheck("R4 erase all", 11'd500, 16'hFFFF);
    special(2'b01); sendBits(32'h5AA5, 16); csDown(); waitProg();
    readCheck("R4 write all", 11'd777, 16'h5AA5);
    orgW = 1'b0;
    special(2'b01); sendBits(32'h96, 8); csDown(); waitProg();
    orgW = 1'b1;
    readCheck("R4 byte write all", 11'd9, 16'h9696);

    // R12 abort
    cmdWrite(11'd20, 16'hBEEF); waitProg();
    issue(2'b01, 11'd20); sendBits(32'h123, 10); csDown();
    noStatus("R12 partial write no cycle");
    csUp(); pulse(1'b1); pulse(1'b1); pulse(1'b1); sendBits(32'h5, 4); csDown();
    noStatus("R12 partial erase no cycle");
    readCheck("R12 memory kept", 11'd20, 16'hBEEF);

    // R3 disabled: ignored, read still works
    special(2'b00); csDown();
    cmdWrite(11'd20, 16'h0000);
    noStatus("R3 write ignored");
    issue(2'b11, 11'd20); csDown();
    special(2'b10); csDown();
    noStatus("R3 erase ignored");
    readCheck("R3 read while disabled", 11'd20, 16'hBEEF);

    // R10 raise after cycle ends
    special(2'b11); csDown();
    cmdWrite(11'd21, 16'h7777);
    waitProg();
    noStatus("R10 no status after done");
    readCheck("R9 late write stored", 11'd21, 16'h7777);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule